// File: doc/BRIEF.md
# Write-Clock Synchronization Sequencer

This block sits in the command-clock domain of a low-power DRAM host interface. Each command-clock cycle it issues a two-bit code that tells the write-clock output stage whether to hold the write clock static, toggle it at half rate or toggle it at full rate. Before any read or write data may move, the write clock has to be brought into step with the command clock. That takes a fixed three-part preamble: a static stretch, one cycle of half-rate toggling, then a full-rate stretch whose length depends on the operating frequency.

A sync request or a data-activity indication starts the preamble when the write clock is off. Once the preamble completes, the block raises a synced flag. While free-running is enabled the write clock then keeps toggling at full rate indefinitely. When free-running is disabled, the block stops the write clock after a run of command-clock cycles with no data activity, which saves power. Stopping the clock drops the synced flag, and the next transfer has to wait for a complete new preamble. The busy flag is high for the whole preamble, so a controller that asks for data while unsynchronized sees busy until the synced flag rises.

Top module: `wck_sync_seq`

## Requirements
- R1: While reset is asserted and in the cycle after it is released with no request, wckMode is 2'b00, synced is 0 and busy is 0.
- R2: When the write clock is off, a cycle with syncReq=1 or dataAct=1 starts the preamble. From the next cycle, wckMode is 2'b00 (static) and busy is 1 for STATIC_CYCLES cycles.
- R3: Directly after the static phase, wckMode is 2'b01 (half rate) for exactly one cycle, with busy still 1.
- R4: After the half-rate cycle, wckMode is 2'b10 (full rate) with busy 1 for fullLen cycles, where fullLen is sampled as the half-rate cycle ends. A fullLen of 0 gives one cycle.
- R5: In the first cycle after the full-rate phase, synced rises and busy falls. wckMode stays 2'b10 for as long as synced is 1.
- R6: syncReq has no effect while the preamble is running or while synced is 1: the phase sequence and the synced flag carry on unchanged.
- R7: With freeRunEn=1, a synced block stays synced with wckMode 2'b10 for any number of cycles, whether or not there is data activity.
- R8: With freeRunEn=0, after IDLE_CYCLES consecutive synced cycles with dataAct=0, wckMode returns to 2'b00 and synced clears in the same cycle. A cycle with dataAct=1 restarts the count.
- R9: After the write clock has been stopped, the block stays off until a new request arrives, and it then runs the complete preamble again before synced rises.
- R10: wckMode never takes the reserved value 2'b11, and synced and busy are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rstN | input | 1 | Active-low synchronous reset |
| syncReq | input | 1 | Request to synchronize the write clock |
| freeRunEn | input | 1 | Keep the write clock toggling once synced |
| fullLen | input | LEN_W | Length of the full-rate phase in cycles (0 means 1) |
| dataAct | input | 1 | Data transfer wanted or in progress this cycle |
| wckMode | output | 2 | 00 static, 01 half rate, 10 full rate |
| synced | output | 1 | Write clock is synchronized; transfers may start |
| busy | output | 1 | Preamble in progress |

## Verification
The hardest situation to reach from the ports is the edge of the idle timeout, where a single cycle of data activity lands just before the count would expire and has to push the shutdown out by a full IDLE_CYCLES. The bench uses a small idle limit. It first lets the count advance, then inserts one active cycle, then counts exactly IDLE_CYCLES quiet cycles and checks that synced stays high until the last of them. After that it restarts from the stopped state with a zero full-rate length and again with the maximum length, and it issues sync requests in the middle of the preamble to confirm they do not restart it.

// File: rtl/wck_seq_pkg.sv
package wck_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_STATIC = 3'd1,
    ST_HALF   = 3'd2,
    ST_FULL   = 3'd3,
    ST_LOCKED = 3'd4
  } seqState_e;

  localparam logic [1:0] MODE_STATIC = 2'b00;
  localparam logic [1:0] MODE_HALF   = 2'b01;
  localparam logic [1:0] MODE_FULL   = 2'b10;

  typedef struct packed {
    logic loadStatic;
    logic loadFull;
    logic tickPhase;
    logic clrIdle;
    logic tickIdle;
  } seqStrobe_t;

endpackage

// File: rtl/wck_seq_dp.sv
module wck_seq_dp
  import wck_seq_pkg::*;
#(
  parameter int LEN_W         = 4,
  parameter int STATIC_CYCLES = 1,
  parameter int IDLE_CYCLES   = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic [LEN_W-1:0] fullLen,
  output logic             phaseLast,
  output logic             idleLast
);

  localparam int ST_W   = $clog2(STATIC_CYCLES + 1);
  localparam int PH_W   = (ST_W > LEN_W) ? ST_W : LEN_W;
  localparam int IDLE_W = $clog2(IDLE_CYCLES + 1);
  localparam logic [PH_W-1:0]   STATIC_LOAD = PH_W'(STATIC_CYCLES - 1);
  localparam logic [IDLE_W-1:0] IDLE_END    = IDLE_W'(IDLE_CYCLES - 1);

  logic [PH_W-1:0]   phaseCnt;
  logic [IDLE_W-1:0] idleCnt;
  logic [PH_W-1:0]   fullLoad;

  // A zero length still gives one full-rate cycle.
  always_comb begin
    if (fullLen == '0) fullLoad = '0;
    else               fullLoad = PH_W'(fullLen) - PH_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseCnt <= '0;
    end else if (strobe.loadStatic) begin
      phaseCnt <= STATIC_LOAD;
    end else if (strobe.loadFull) begin
      phaseCnt <= fullLoad;
    end else if (strobe.tickPhase && phaseCnt != '0) begin
      phaseCnt <= phaseCnt - PH_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idleCnt <= '0;
    end else if (strobe.clrIdle) begin
      idleCnt <= '0;
    end else if (strobe.tickIdle) begin
      idleCnt <= idleCnt + IDLE_W'(1);
    end
  end

  assign phaseLast = (phaseCnt == '0);
  assign idleLast  = (idleCnt == IDLE_END);

endmodule

// File: rtl/wck_seq_ctrl.sv
module wck_seq_ctrl
  import wck_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       syncReq,
  input  logic       freeRunEn,
  input  logic       dataAct,
  input  logic       phaseLast,
  input  logic       idleLast,
  output seqStrobe_t strobe,
  output logic [1:0] wckMode,
  output logic       synced,
  output logic       busy
);

  seqState_e state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_OFF: begin
        if (syncReq || dataAct) begin
          stateNext         = ST_STATIC;
          strobe.loadStatic = 1'b1;
        end
      end
      ST_STATIC: begin
        strobe.tickPhase = 1'b1;
        if (phaseLast) stateNext = ST_HALF;
      end
      ST_HALF: begin
        stateNext       = ST_FULL;
        strobe.loadFull = 1'b1;
      end
      ST_FULL: begin
        strobe.tickPhase = 1'b1;
        if (phaseLast) begin
          stateNext      = ST_LOCKED;
          strobe.clrIdle = 1'b1;
        end
      end
      ST_LOCKED: begin
        if (freeRunEn || dataAct) begin
          strobe.clrIdle = 1'b1;
        end else if (idleLast) begin
          stateNext      = ST_OFF;
          strobe.clrIdle = 1'b1;
        end else begin
          strobe.tickIdle = 1'b1;
        end
      end
      default: stateNext = ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_OFF;
    else       state <= stateNext;
  end

  always_comb begin
    unique case (state)
      ST_HALF:            wckMode = MODE_HALF;
      ST_FULL, ST_LOCKED: wckMode = MODE_FULL;
      default:            wckMode = MODE_STATIC;
    endcase
  end

  assign synced = (state == ST_LOCKED);
  assign busy   = (state == ST_STATIC) || (state == ST_HALF) || (state == ST_FULL);

endmodule

// File: rtl/wck_sync_seq.sv
module wck_sync_seq
  import wck_seq_pkg::*;
#(
  parameter int LEN_W         = 4,
  parameter int STATIC_CYCLES = 1,
  parameter int IDLE_CYCLES   = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             syncReq,
  input  logic             freeRunEn,
  input  logic [LEN_W-1:0] fullLen,
  input  logic             dataAct,
  output logic [1:0]       wckMode,
  output logic             synced,
  output logic             busy
);

  seqStrobe_t strobe;
  logic       phaseLast;
  logic       idleLast;

  wck_seq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .syncReq   (syncReq),
    .freeRunEn (freeRunEn),
    .dataAct   (dataAct),
    .phaseLast (phaseLast),
    .idleLast  (idleLast),
    .strobe    (strobe),
    .wckMode   (wckMode),
    .synced    (synced),
    .busy      (busy)
  );

  wck_seq_dp #(
    .LEN_W         (LEN_W),
    .STATIC_CYCLES (STATIC_CYCLES),
    .IDLE_CYCLES   (IDLE_CYCLES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .fullLen   (fullLen),
    .phaseLast (phaseLast),
    .idleLast  (idleLast)
  );

endmodule

// File: rtl/wck_sync_seq_chk.sv
module wck_sync_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       syncReq,
  input logic       freeRunEn,
  input logic       dataAct,
  input logic [1:0] wckMode,
  input logic       synced,
  input logic       busy
);

  p_no_reserved_r10: assert property (@(posedge clk) disable iff (!rstN)
    wckMode != 2'b11);

  p_excl_flags_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(synced && busy));

  p_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!synced && !busy && (syncReq || dataAct)) |=> busy);

  p_half_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wckMode == 2'b01) |=> (wckMode == 2'b10));

  p_lock_entry_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(synced) |-> ($past(busy) && $past(wckMode) == 2'b10));

  p_lock_mode_r5: assert property (@(posedge clk) disable iff (!rstN)
    synced |-> (wckMode == 2'b10));

  p_free_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (synced && freeRunEn) |=> synced);

  p_active_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (synced && dataAct) |=> synced);

  p_stop_clean_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(synced) |-> (wckMode == 2'b00 && !busy));

endmodule

bind wck_sync_seq wck_sync_seq_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .syncReq   (syncReq),
  .freeRunEn (freeRunEn),
  .dataAct   (dataAct),
  .wckMode   (wckMode),
  .synced    (synced),
  .busy      (busy)
);

// File: tb/sim_wck_sync_seq.sv
module sim_wck_sync_seq;

  localparam int LEN_W  = 4;
  localparam int ST_CYC = 2;
  localparam int IDLE   = 4;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             syncReq = 1'b0;
  logic             freeRunEn = 1'b0;
  logic [LEN_W-1:0] fullLen = '0;
  logic             dataAct = 1'b0;
  logic [1:0]       wckMode;
  logic             synced;
  logic             busy;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  typedef struct {
    logic [1:0] mode;
    logic       sync;
    logic       bsy;
    string      tag;
  } expItem_t;

  expItem_t expQ[$];

  always #4 clk = ~clk;

  wck_sync_seq #(
    .LEN_W         (LEN_W),
    .STATIC_CYCLES (ST_CYC),
    .IDLE_CYCLES   (IDLE)
  ) u0 (
    .clk       (clk),
    .rstN      (rstN),
    .syncReq   (syncReq),
    .freeRunEn (freeRunEn),
    .fullLen   (fullLen),
    .dataAct   (dataAct),
    .wckMode   (wckMode),
    .synced    (synced),
    .busy      (busy)
  );

  // Driver: apply inputs for one cycle, queue the outputs expected after the edge.
  task automatic cyc(input logic req, input logic fr, input logic [LEN_W-1:0] len,
                     input logic act, input logic [1:0] eMode, input logic eSync,
                     input logic eBusy, input string tag);
    expItem_t it;
    @(negedge clk);
    syncReq   = req;
    freeRunEn = fr;
    fullLen   = len;
    dataAct   = act;
    it.mode = eMode;
    it.sync = eSync;
    it.bsy  = eBusy;
    it.tag  = tag;
    expQ.push_back(it);
  endtask

  // Monitor: compare after each edge has settled.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        nChecks++;
        if (wckMode !== it.mode || synced !== it.sync || busy !== it.bsy) begin
          nFails++;
          $display("FAIL %s: got mode=%b synced=%b busy=%b, expected mode=%b synced=%b busy=%b",
                   it.tag, wckMode, synced, busy, it.mode, it.sync, it.bsy);
        end
        nChecks++;
        if (wckMode === 2'b11 || (synced === 1'b1 && busy === 1'b1)) begin
          nFails++;
          $display("FAIL R10: got mode=%b synced=%b busy=%b, expected mode!=11 and not both flags",
                   wckMode, synced, busy);
        end
      end
    end
  end

  // Full preamble from the off state, started by the caller's first cycle.
  task automatic preamble(input logic useReq, input logic [LEN_W-1:0] len, input logic fr);
    int n;
    n = (len == 0) ? 1 : int'(len);
    cyc(useReq, fr, len, !useReq, 2'b00, 1'b0, 1'b1, "R2 static start");
    for (int i = 1; i < ST_CYC; i++)
      cyc(1'b0, fr, len, 1'b0, 2'b00, 1'b0, 1'b1, "R2 static hold");
    cyc(1'b1, fr, len, 1'b0, 2'b01, 1'b0, 1'b1, "R3 half rate");
    for (int i = 0; i < n; i++)
      cyc(1'b1, fr, len, 1'b0, 2'b10, 1'b0, 1'b1, "R4 full rate, R6 req ignored");
    cyc(1'b0, fr, len, 1'b0, 2'b10, 1'b1, 1'b0, "R5 synced rises");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    nChecks++;
    if (wckMode !== 2'b00 || synced !== 1'b0 || busy !== 1'b0) begin
      nFails++;
      $display("FAIL R1: got mode=%b synced=%b busy=%b in reset, expected 00/0/0",
               wckMode, synced, busy);
    end
    rstN = 1'b1;
    cyc(1'b0, 1'b1, 4'd3, 1'b0, 2'b00, 1'b0, 1'b0, "R1 idle after reset");
    cyc(1'b0, 1'b1, 4'd3, 1'b0, 2'b00, 1'b0, 1'b0, "R1 idle after reset");

    // Sync request, length 3, free-running.
    preamble(1'b1, 4'd3, 1'b1);
    for (int i = 0; i < 8; i++)
      cyc(i[0], 1'b1, 4'd3, 1'b0, 2'b10, 1'b1, 1'b0, "R7 free-run hold, R6 req ignored");

    // Idle timeout with one active cycle restarting the count.
    cyc(1'b0, 1'b0, 4'd3, 1'b0, 2'b10, 1'b1, 1'b0, "R8 idle count 1");
    cyc(1'b0, 1'b0, 4'd3, 1'b0, 2'b10, 1'b1, 1'b0, "R8 idle count 2");
    cyc(1'b0, 1'b0, 4'd3, 1'b1, 2'b10, 1'b1, 1'b0, "R8 activity clears count");
    for (int i = 1; i < IDLE; i++)
      cyc(1'b0, 1'b0, 4'd3, 1'b0, 2'b10, 1'b1, 1'b0, "R8 still synced");
    cyc(1'b0, 1'b0, 4'd3, 1'b0, 2'b00, 1'b0, 1'b0, "R8 stop on limit");
    cyc(1'b0, 1'b0, 4'd3, 1'b0, 2'b00, 1'b0, 1'b0, "R9 stays off");
    cyc(1'b0, 1'b0, 4'd3, 1'b0, 2'b00, 1'b0, 1'b0, "R9 stays off");

    // Data activity restarts with zero length.
    preamble(1'b0, 4'd0, 1'b0);
    cyc(1'b0, 1'b0, 4'd0, 1'b1, 2'b10, 1'b1, 1'b0, "R8 active keeps synced");
    for (int i = 1; i < IDLE; i++)
      cyc(1'b0, 1'b0, 4'd0, 1'b0, 2'b10, 1'b1, 1'b0, "R8 counting");
    cyc(1'b0, 1'b0, 4'd0, 1'b0, 2'b00, 1'b0, 1'b0, "R8 stop");

    // Maximum length after a stop.
    preamble(1'b1, 4'd15, 1'b1);
    cyc(1'b0, 1'b1, 4'd15, 1'b0, 2'b10, 1'b1, 1'b0, "R7 hold");

    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (5000) @(posedge clk);
        nChecks++;
        nFails++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule